// File: doc/BRIEF.md
# I2C Register Target with Persistent Pointer

This block is the target side of a two-wire serial bus, serving a ten-entry register file of bytes. It watches synchronized copies of the clock and data lines and recognizes start, repeated start and stop conditions. It matches the first byte of each transfer against a fixed 7-bit device address. When the address matches, it acknowledges and either takes bytes into the register file or sends register contents back to the master.

All accesses go through one register pointer. The pointer keeps its value from one transfer to the next and steps from the last register back to the first. A read with no setup, called a current-address read, therefore continues where the previous access stopped. A random read begins as a write that only sets the pointer. A repeated start then turns the same transfer into a read from that register. The data line is open-drain: the block only pulls it low, through an output enable. The register file sits outside the block and is reached through a plain address, write-strobe, write-data and read-data port.

Top module: `i2c_reg_target`

## Requirements
- R1: A start condition (data falls while clock is high) begins address reception from any state, including in the middle of a transfer (repeated start). A stop condition (data rises while clock is high) returns the block to idle with the data line released.
- R2: The first byte after a start carries the device address in bits 7..1 (default 7'h1A) and the direction in bit 0 (1 = read, 0 = write). On a match the block pulls data low during the ninth clock. On a mismatch it gives no acknowledge, makes no register write, leaves the pointer unchanged and ignores the bus until the next start or stop.
- R3: In a write transfer the first byte after the address is a register number. It is acknowledged and loaded into the pointer, and a value of 10 or more loads 0. This byte does not advance the pointer.
- R4: Each later byte of a write transfer is written to the register at the pointer with a single write strobe and is acknowledged. The pointer then advances by one. A byte cut short by a start or stop is not written.
- R5: In a read transfer the block sends the register at the pointer, most significant bit first, starting right after the address acknowledge. It advances the pointer once per byte sent, changes the data enable only while clock is low, and releases data during the master's acknowledge bit.
- R6: If the master acknowledges (data low) a sent byte, the next register follows. If it does not, the block releases data and drives nothing more until the next start.
- R7: The pointer steps from register 9 to register 0, for both reads and writes.
- R8: The pointer keeps its value across transfers, so a current-address read starts one past the last register accessed by either a read or a write.
- R9: A write of a register number followed by a repeated start and a read address reads first from that register number.
- R10: After reset the data line is released, no write strobe is active and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls the data line low; 0 releases it |
| regAddr | output | 4 | Register pointer; addresses both read and write |
| regWrEn | output | 1 | One-cycle write strobe to the register file |
| regWrData | output | 8 | Byte to write at regAddr |
| regRdData | input | 8 | Register file contents at regAddr, combinational |

## Verification
Two functions can land in the same cycle: receiving a write-data bit and detecting a start or stop. The master's clock rise just before a repeated start or a stop clocks a bit into the write shifter, and the condition follows while that byte is incomplete. Every random read and every stop after a write provokes this, mixed with directed and seeded random transfers. The result is judged at the ports: the register file must show no write beyond the counted complete bytes, and the pointer must equal the loaded register number plus only the bytes actually transferred.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_REGADDR,
    ST_REGACK,
    ST_WRDATA,
    ST_WRACK,
    ST_RDDATA,
    ST_RDACK
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic ptrLoad;
    logic ptrInc;
    logic wrStrobe;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic relSda;
  } tgtStrobe_t;

endpackage

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int PTR_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  tgtStrobe_t       stb,
  input  logic [7:0]       regRdData,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startEv,
  output logic             stopEv,
  output logic             sdaSync,
  output logic [7:0]       rxByte,
  output logic             sdaOe,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev;
  logic       sclSync;
  logic [7:0] txByte;

  // two-flop synchronizers plus one history stage; idle bus is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclPrev <= sclPipe[1];
      sdaPrev <= sdaPipe[1];
    end
  end

  assign sclSync = sclPipe[1];
  assign sdaSync = sdaPipe[1];
  assign sclRise = sclSync & ~sclPrev;
  assign sclFall = ~sclSync & sclPrev;
  assign startEv = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopEv  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  // receive shifter, MSB first
  always_ff @(posedge clk) begin
    if (!rstN)            rxByte <= '0;
    else if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaSync};
  end

  // transmit shifter and open-drain enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte <= '0;
      sdaOe  <= 1'b0;
    end else if (stb.relSda) begin
      sdaOe  <= 1'b0;
    end else if (stb.driveAck) begin
      sdaOe  <= 1'b1;
    end else if (stb.loadTx) begin
      txByte <= regRdData;
      sdaOe  <= ~regRdData[7];
    end else if (stb.shiftTx) begin
      txByte <= {txByte[6:0], 1'b0};
      sdaOe  <= ~txByte[6];
    end
  end

  // shared register pointer with wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.ptrLoad) begin
      ptr <= (int'(rxByte) < NUM_REGS) ? rxByte[PTR_W-1:0] : '0;
    end else if (stb.ptrInc) begin
      ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptr) < NUM_REGS);                                           // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrInc && !stb.ptrLoad && ptr == LAST_PTR) |=> ptr == '0);  // R7
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclSync);                                   // R5
  AST_WR_THEN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStrobe |=> sdaOe);                                         // R4

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sdaSync,
  input  logic [7:0] rxByte,
  output tgtStrobe_t stb,
  output logic       idle
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_BITS - 1);

  tgtState_e        state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic             isRead, isReadNxt;
  logic             mAck, mAckNxt;

  always_comb begin
    stb       = '0;
    stateNxt  = state;
    cntNxt    = bitCnt;
    isReadNxt = isRead;
    mAckNxt   = mAck;
    if (startEv) begin
      stateNxt   = ST_DEVADDR;
      cntNxt     = '0;
      stb.relSda = 1'b1;
    end else if (stopEv) begin
      stateNxt   = ST_IDLE;
      cntNxt     = '0;
      stb.relSda = 1'b1;
    end else begin
      case (state)
        ST_DEVADDR, ST_REGADDR, ST_WRDATA: begin
          if (sclRise && bitCnt != FULL_CNT) begin
            stb.shiftIn = 1'b1;
            cntNxt      = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            cntNxt = '0;
            if (state == ST_DEVADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stb.driveAck = 1'b1;
                isReadNxt    = rxByte[0];
                stateNxt     = ST_DEVACK;
              end else begin
                stateNxt = ST_IDLE;
              end
            end else if (state == ST_REGADDR) begin
              stb.ptrLoad  = 1'b1;
              stb.driveAck = 1'b1;
              stateNxt     = ST_REGACK;
            end else begin
              stb.wrStrobe = 1'b1;
              stb.ptrInc   = 1'b1;
              stb.driveAck = 1'b1;
              stateNxt     = ST_WRACK;
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            cntNxt = '0;
            if (isRead) begin
              stb.loadTx = 1'b1;
              stb.ptrInc = 1'b1;
              stateNxt   = ST_RDDATA;
            end else begin
              stb.relSda = 1'b1;
              stateNxt   = ST_REGADDR;
            end
          end
        end
        ST_REGACK, ST_WRACK: begin
          if (sclFall) begin
            stb.relSda = 1'b1;
            cntNxt     = '0;
            stateNxt   = ST_WRDATA;
          end
        end
        ST_RDDATA: begin
          if (sclFall) begin
            if (bitCnt == LAST_TX) begin
              stb.relSda = 1'b1;
              cntNxt     = '0;
              stateNxt   = ST_RDACK;
            end else begin
              stb.shiftTx = 1'b1;
              cntNxt      = bitCnt + 1'b1;
            end
          end
        end
        ST_RDACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaSync;
          end else if (sclFall) begin
            if (mAck) begin
              stb.loadTx = 1'b1;
              stb.ptrInc = 1'b1;
              cntNxt     = '0;
              stateNxt   = ST_RDDATA;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= cntNxt;
      isRead <= isReadNxt;
      mAck   <= mAckNxt;
    end
  end

  assign idle = (state == ST_IDLE);

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> state == ST_DEVADDR);                                // R1
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrStrobe, stb.loadTx, stb.ptrLoad}));              // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && !startEv) |=> idle);                                  // R1

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter int         NUM_REGS = 10,
  localparam int        PTR_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  output logic [PTR_W-1:0] regAddr,
  output logic             regWrEn,
  output logic [7:0]       regWrData,
  input  logic [7:0]       regRdData
);

  tgtStrobe_t       stb;
  logic             sclRise, sclFall, startEv, stopEv, sdaSync, idle;
  logic [7:0]       rxByte;
  logic [PTR_W-1:0] ptr;

  i2c_tgt_dp #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .regRdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaSync(sdaSync),
    .rxByte(rxByte), .sdaOe(sdaOe), .ptr(ptr)
  );

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaSync(sdaSync),
    .rxByte(rxByte), .stb(stb), .idle(idle)
  );

  assign regAddr   = ptr;
  assign regWrEn   = stb.wrStrobe;
  assign regWrData = rxByte;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !sdaOe);                                                // R6

endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam int NUM_REGS   = 10;
  localparam logic [6:0] DEV = 7'h1A;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sdaOe, regWrEn;
  logic [3:0] regAddr;
  logic [7:0] regWrData, regRdData;
  wire        sdaLine = sdaM & ~sdaOe;

  i2c_reg_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  logic [7:0] regFile [NUM_REGS];
  logic [7:0] expReg  [NUM_REGS];
  int expPtr = 0, nChecks = 0, nErr = 0;
  int wrCount = 0, expWrites = 0, oeViol = 0;
  logic prevOe = 1'b0;

  assign regRdData = (int'(regAddr) < NUM_REGS) ? regFile[regAddr] : 8'h00;
  always @(posedge clk) if (regWrEn && int'(regAddr) < NUM_REGS) regFile[regAddr] <= regWrData;

  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) wrCount++;
      if (sclM && sdaOe !== prevOe) oeViol++;
    end
    prevOe = sdaOe;
  end

  function automatic int nextP(int p);
    return (p == NUM_REGS - 1) ? 0 : p + 1;
  endfunction
  function automatic int loadP(int a);
    return (a < NUM_REGS) ? a : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic doStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic doStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask
  task automatic writeBit(logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); b = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic sendByte(logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(a);
    acked = ~a;
  endtask
  task automatic recvByte(logic giveAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) readBit(d[i]);
    writeBit(~giveAck);
  endtask

  task automatic readBytes(string req, int n);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      check(req, b, expReg[expPtr]);
      expPtr = nextP(expPtr);
    end
    check("R6 data released after master nack", sdaOe, 0);
  endtask

  task automatic writeTxn(logic [7:0] ra, int n);
    logic ack;
    logic [7:0] d;
    doStart();
    sendByte({DEV, 1'b0}, ack); check("R2 write address ack", ack, 1);
    sendByte(ra, ack);          check("R3 register number ack", ack, 1);
    expPtr = loadP(ra);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sendByte(d, ack); check("R4 data ack", ack, 1);
      expReg[expPtr] = d;
      expPtr = nextP(expPtr);
      expWrites++;
    end
    doStop();
    check("R8 pointer after write", int'(regAddr), expPtr);
    for (int i = 0; i < NUM_REGS; i++) check("R4 register contents", regFile[i], expReg[i]);
  endtask

  task automatic readCur(int n);
    logic ack;
    doStart();
    sendByte({DEV, 1'b1}, ack); check("R2 read address ack", ack, 1);
    readBytes("R8 current-address read data", n);
    doStop();
    check("R8 pointer after read", int'(regAddr), expPtr);
  endtask

  task automatic readRand(logic [7:0] ra, int n);
    logic ack;
    doStart();
    sendByte({DEV, 1'b0}, ack); check("R9 dummy write ack", ack, 1);
    sendByte(ra, ack);          check("R9 register number ack", ack, 1);
    expPtr = loadP(ra);
    doStart();
    sendByte({DEV, 1'b1}, ack); check("R9 read address ack", ack, 1);
    readBytes("R9 random read data", n);
    doStop();
    check("R9 pointer after random read", int'(regAddr), expPtr);
  endtask

  task automatic badAddr(logic [6:0] flip, logic rw);
    logic ack;
    int wrBefore;
    wrBefore = wrCount;
    doStart();
    sendByte({DEV ^ flip, rw}, ack); check("R2 mismatch not acked", ack, 0);
    sendByte(8'h00, ack);            check("R2 following byte ignored", ack, 0);
    doStop();
    check("R2 pointer unchanged on mismatch", int'(regAddr), expPtr);
    check("R2 no write on mismatch", wrCount, wrBefore);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    for (int i = 0; i < NUM_REGS; i++) begin
      regFile[i] = 8'(i * 37 + 5);
      expReg[i]  = 8'(i * 37 + 5);
    end
    repeat (5) @(negedge clk);
    check("R10 data released in reset", sdaOe, 0);
    check("R10 no write in reset", regWrEn, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 pointer zero after reset", int'(regAddr), 0);
    check("R10 data released after reset", sdaOe, 0);

    writeTxn(8'd8, 3);                 // R7 write wraps 9 -> 0
    check("R7 pointer wrapped in write", int'(regAddr), 1);
    readCur(2);                        // R8 continues at 1
    readRand(8'd9, 3);                 // R9, R7 read wraps
    check("R7 pointer wrapped in read", int'(regAddr), 2);
    writeTxn(8'h3C, 0);                // R3 out-of-range number loads 0
    check("R3 large register number loads 0", int'(regAddr), 0);
    writeTxn(8'd5, 0);                 // R3 no increment on number byte
    check("R3 number byte does not advance", int'(regAddr), 5);
    badAddr(7'h01, 1'b1);
    badAddr(7'h40, 1'b0);
    readCur(1);                        // R2 pointer kept after mismatch
    readCur(12);                       // R6 long acked burst, R7 wrap

    for (int t = 0; t < 30; t++) begin
      case ($urandom % 4)
        0: writeTxn(8'($urandom % 12), int'($urandom % 4));
        1: readCur(1 + int'($urandom % 4));
        2: readRand(8'($urandom % 12), 1 + int'($urandom % 4));
        default: badAddr(7'(1 + $urandom % 127), 1'($urandom));
      endcase
    end

    check("R5 enable changed only while clock low", oeViol, 0);
    check("R4 write strobes equal complete bytes", wrCount, expWrites);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule